// File: doc/BRIEF.md
# Serial Control Port Register Bank for an Audio Codec

This block receives write-only configuration traffic for the mixer and volume settings of a stereo audio codec and keeps the results in a small register bank. A host sends framed 16-bit words over three wires: an active-low select, a control clock and a data line. Each accepted word carries an address byte and then a data byte. The block decodes the address, masks the data to the bits the target register implements, and stores it. All register contents are presented together on one flat parallel bus for the analog and mixing logic downstream.

The control clock, select and data inputs are not used as clocks. They are resynchronised into the system clock domain together with an external power-down pin, and their edges are found there. The pin is active low. Two controls block or undo writes. While the pin is low the whole bank is held at its reset values. A run bit inside the bank can also be cleared by software. While it is clear, every other register is held at its reset value, and only the register that holds the run bit can be written.

Top module: `codec_ctl_port`

## Requirements
- R1: A frame is the span during which `csel_n` is low. On each rising `cclk` edge inside the frame, one `cdin` bit is captured. The first 8 bits form the address and the next 8 bits form the data, each sent most-significant bit first. The write takes effect only after `csel_n` returns high.
- R2: A frame with fewer or more than 16 rising `cclk` edges is discarded and leaves every register unchanged.
- R3: Only the low 5 address bits are decoded. For example, addresses 0x20 and 0xE0 write the register at 0x00.
- R4: `reg_bus` holds 16 byte slots, and slot s occupies bits [8s+7:8s]. The slots are assigned as follows:
  - Slots 0 to 3 hold addresses 0x00 to 0x03.
  - Slots 4 to 7 hold addresses 0x08 to 0x0B.
  - Slots 8 to 13 hold addresses 0x10 to 0x15.
  - Slot 14 holds address 0x16, which is the control register.
  - Slot 15 holds address 0x19.

  The reset values are:
  - Slots 0 and 1: 0x00.
  - Slots 2 to 7: 0x06.
  - Slots 8, 12 and 13: 0x00.
  - Slot 9: 0x0C.
  - Slot 10: 0x10.
  - Slot 11: 0x08.
  - Slot 14: 0x03.
  - Slot 15: 0x00.
- R5: A write stores the data ANDed with the register's implemented-bit mask. The masks are:
  - Slots 0 to 7: 0x9F, with the mute flag at bit 7 and the level code in bits 4:0.
  - Slots 8 to 13: 0x1F.
  - Slot 14: 0x03, with bit 1 as the power-enable bit and bit 0 as the run bit.
  - Slot 15: 0x01.
- R6: A write to an unmapped address is discarded, and this includes the reserved address 0x1A.
- R7: While the run bit (slot 14, bit 0) is 0, every slot other than 14 is held at its reset value and writes to those slots are ignored. Slot 14 remains writable.
- R8: While `pwr_pin_n` is low, every slot is held at its reset value, slot 14 reads 0x03, and all writes are ignored.
- R9: No slot changes unless a write is accepted, the pin is low, or the run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwr_pin_n | input | 1 | External power-down pin, active low |
| csel_n | input | 1 | Serial frame select, active low |
| cclk | input | 1 | Serial control clock, sampled on its rising edge |
| cdin | input | 1 | Serial control data |
| reg_bus | output | 128 | All 16 register slots, slot s at bits [8s+7:8s] |

## Verification
The hardest state to reach is a bank that is being reinitialised while frames keep arriving. To get there, the stimulus first clears the run bit through a serial write and then sends writes to ordinary registers, which must stay at their reset values. It then drops the power pin after the control register has been written to a non-default value, so that the forced value 0x03 differs visibly from what was stored. Frames one bit short and one bit long are sent to show that the edge counter, not just the select timing, decides acceptance.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int NREG      = 16;
  localparam int SLOT_W    = $clog2(NREG);
  localparam int DEC_W     = 5;
  localparam int CTRL_SLOT = 14;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } dec_t;

  // Address (low bits only) to storage slot.
  function automatic dec_t decode(input logic [DEC_W-1:0] a);
    dec_t d;
    d.hit  = 1'b1;
    d.slot = '0;
    case (a)
      5'h00, 5'h01, 5'h02, 5'h03: d.slot = SLOT_W'(a);
      5'h08, 5'h09, 5'h0A, 5'h0B: d.slot = SLOT_W'(a - 5'h04);
      5'h10, 5'h11, 5'h12, 5'h13,
      5'h14, 5'h15, 5'h16:        d.slot = SLOT_W'(a - 5'h08);
      5'h19:                      d.slot = SLOT_W'(15);
      default:                    d.hit  = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(input int s);
    case (s)
      2, 3, 4, 5, 6, 7: return DATA_W'(8'h06);
      9:                return DATA_W'(8'h0C);
      10:               return DATA_W'(8'h10);
      11:               return DATA_W'(8'h08);
      CTRL_SLOT:        return DATA_W'(8'h03);
      default:          return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] wmask(input int s);
    if (s < 8)               return DATA_W'(8'h9F);
    else if (s < CTRL_SLOT)  return DATA_W'(8'h1F);
    else if (s == CTRL_SLOT) return DATA_W'(8'h03);
    else                     return DATA_W'(8'h01);
  endfunction
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int              WIDTH  = 4,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= INIT;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ccp_deser.sv
module ccp_deser #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sck_s,
  input  logic               sd_s,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic             sck_q, cs_q;
  logic [CNT_W-1:0] cnt;
  logic             sck_rise;

  assign sck_rise = sck_s & ~sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      cnt        <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      sck_q     <= sck_s;
      cs_q      <= cs_n_s;
      frame_vld <= 1'b0;
      if (!cs_n_s) begin
        if (sck_rise) begin
          frame_word <= {frame_word[FRAME_W-2:0], sd_s};
          if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
        end
      end else begin
        if (!cs_q) frame_vld <= (cnt == CNT_W'(FRAME_W));
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ccp_bank.sv
module ccp_bank
  import ccp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_low,
  input  logic                   wr_stb,
  input  logic [DEC_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] reg_bus,
  output logic                   run_low,
  output logic                   wr_en
);
  logic [DATA_W-1:0] r [NREG];
  dec_t              dec;

  assign dec     = decode(wr_addr);
  assign run_low = ~r[CTRL_SLOT][0];
  assign wr_en   = wr_stb & ~pwr_low & dec.hit &
                   ((int'(dec.slot) == CTRL_SLOT) | ~run_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NREG; s++) r[s] <= reset_val(s);
    end else if (pwr_low) begin
      for (int s = 0; s < NREG; s++) r[s] <= reset_val(s);
    end else begin
      if (run_low) begin
        for (int s = 0; s < NREG; s++)
          if (s != CTRL_SLOT) r[s] <= reset_val(s);
      end
      if (wr_en) r[dec.slot] <= wr_data & wmask(int'(dec.slot));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_bus[g*DATA_W +: DATA_W] = r[g];
  end
endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
  import ccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_pin_n,
  input  logic                   csel_n,
  input  logic                   cclk,
  input  logic                   cdin,
  output logic [NREG*DATA_W-1:0] reg_bus
);
  logic [3:0]         sync_q;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_word;
  logic [ADDR_W-1:0]  frame_addr;
  logic               pwr_low;
  logic               run_low;
  logic               wr_en;

  ccp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .INIT(4'b0001)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pwr_pin_n, cdin, cclk, csel_n}),
    .q    (sync_q)
  );

  assign pwr_low = ~sync_q[3];

  ccp_deser #(.FRAME_W(FRAME_W)) deser_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (sync_q[0]),
    .sck_s     (sync_q[1]),
    .sd_s      (sync_q[2]),
    .frame_vld (frame_vld),
    .frame_word(frame_word)
  );

  assign frame_addr = frame_word[FRAME_W-1 -: ADDR_W];

  ccp_bank bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_low(pwr_low),
    .wr_stb (frame_vld),
    .wr_addr(frame_addr[DEC_W-1:0]),
    .wr_data(frame_word[DATA_W-1:0]),
    .reg_bus(reg_bus),
    .run_low(run_low),
    .wr_en  (wr_en)
  );
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker
  import ccp_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_vld,
  input logic [ADDR_W-1:0]      frame_addr,
  input logic                   wr_en,
  input logic                   pwr_low,
  input logic                   run_low,
  input logic [NREG*DATA_W-1:0] reg_bus
);
  AST_WRITE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> frame_vld); // R1

  AST_TEST_ADDR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame_addr[DEC_W-1:0] == 5'h1A) |-> !wr_en); // R6

  AST_PIN_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_low |-> !wr_en); // R8

  AST_PIN_FORCES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_low |=> (reg_bus[CTRL_SLOT*DATA_W +: DATA_W] == 8'h03)); // R8

  AST_RUN_LOW_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_low && run_low) |=>
      (reg_bus[7:0] == 8'h00 && reg_bus[23:16] == 8'h06)); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pwr_low && !run_low) |=> $stable(reg_bus)); // R9
endmodule

bind codec_ctl_port ccp_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_vld (frame_vld),
  .frame_addr(frame_addr),
  .wr_en     (wr_en),
  .pwr_low   (pwr_low),
  .run_low   (run_low),
  .reg_bus   (reg_bus)
);

// File: tb/codec_ctl_port_tb_top.sv
module codec_ctl_port_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwr_pin_n = 1'b1;
  logic         csel_n = 1'b1;
  logic         cclk = 1'b0;
  logic         cdin = 1'b0;
  logic [127:0] reg_bus;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic [7:0] exp_r [16];

  always #10 clk = ~clk;

  codec_ctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_pin_n(pwr_pin_n),
    .csel_n(csel_n), .cclk(cclk), .cdin(cdin), .reg_bus(reg_bus)
  );

  // {address, data, expected stored value}
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00FF9F, 24'h018585, 24'h021F1F, 24'h038080, 24'h0BE181,
    24'h11FF1F, 24'h130303, 24'h19FF01, 24'h15AA0A, 24'h291212,
    24'h0A3C1C
  };

  function automatic int b_slot(input logic [7:0] a);
    case (a & 8'h1F)
      8'h00: return 0;  8'h01: return 1;  8'h02: return 2;  8'h03: return 3;
      8'h08: return 4;  8'h09: return 5;  8'h0A: return 6;  8'h0B: return 7;
      8'h10: return 8;  8'h11: return 9;  8'h12: return 10; 8'h13: return 11;
      8'h14: return 12; 8'h15: return 13; 8'h16: return 14; 8'h19: return 15;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] b_reset(input int s);
    if (s >= 2 && s <= 7) return 8'h06;
    if (s == 9)  return 8'h0C;
    if (s == 10) return 8'h10;
    if (s == 11) return 8'h08;
    if (s == 14) return 8'h03;
    return 8'h00;
  endfunction

  task automatic model_reset(input bit keep_ctrl);
    for (int s = 0; s < 16; s++)
      if (!(keep_ctrl && s == 14)) exp_r[s] = b_reset(s);
  endtask

  task automatic check_slot(input int s, input logic [7:0] e, input string tag);
    n_checks++;
    if (reg_bus[s*8 +: 8] !== e) begin
      n_errors++;
      $display("FAIL %s slot %0d: actual %02h expected %02h", tag, s, reg_bus[s*8 +: 8], e);
    end
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 16; s++) check_slot(s, exp_r[s], tag);
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] w;
    w = {a, d};
    @(negedge clk); csel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      cdin = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk); cclk = 1'b1;
      repeat (4) @(negedge clk); cclk = 1'b0;
    end
    repeat (4) @(negedge clk); csel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R4: reset values in their slots
    model_reset(1'b0);
    check_all("R4 reset");

    // R1 R3 R5: table of writes
    for (int v = 0; v < NVEC; v++) begin
      int s;
      send(VEC[v][23:16], VEC[v][15:8], 16);
      s = b_slot(VEC[v][23:16]);
      exp_r[s] = VEC[v][7:0];
      check_slot(s, VEC[v][7:0], "R1 R5 table");
      check_all("R3 table bank");
    end

    // R3: aliased upper address bits
    send(8'h20, 8'h07, 16); exp_r[0] = 8'h07; check_all("R3 alias 20");
    send(8'hE0, 8'h09, 16); exp_r[0] = 8'h09; check_all("R3 alias E0");

    // R6: reserved and unmapped addresses
    send(8'h1A, 8'hFF, 16); check_all("R6 addr 1A");
    send(8'h3A, 8'hFF, 16); check_all("R6 alias 1A");
    send(8'h1C, 8'hFF, 16); check_all("R6 unmapped");

    // R2: wrong frame lengths
    send(8'h00, 8'h1F, 15); check_all("R2 short frame");
    send(8'h00, 8'h1F, 17); check_all("R2 long frame");

    // R7: run bit cleared
    send(8'h16, 8'h02, 16);
    model_reset(1'b1); exp_r[14] = 8'h02;
    check_all("R7 reinit");
    send(8'h00, 8'h05, 16); check_all("R7 write ignored");
    send(8'h16, 8'h03, 16); exp_r[14] = 8'h03; check_all("R7 ctrl writable");
    send(8'h00, 8'h05, 16); exp_r[0] = 8'h05; check_all("R7 writes resume");

    // R8: power pin
    send(8'h16, 8'h01, 16); exp_r[14] = 8'h01; check_all("R8 setup");
    @(negedge clk); pwr_pin_n = 1'b0;
    repeat (6) @(negedge clk);
    model_reset(1'b0);
    check_all("R8 pin low");
    send(8'h00, 8'h11, 16); check_all("R8 write ignored");
    send(8'h16, 8'h00, 16); check_all("R8 ctrl write ignored");
    @(negedge clk); pwr_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R8 released");
    send(8'h01, 8'h8A, 16); exp_r[1] = 8'h8A; check_all("R9 after release");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule